// File: doc/BRIEF.md
# Two-Stage Pipelined Data Cache Access Path

This block is the lookup and store-commit datapath of a direct-mapped data cache of 32-bit words, split over two pipeline stages. In the read stage the tag array and the data array are both read from the request's index in the same cycle, and the tag comparison decides hit or miss. At the boundary into the write stage the outcome, the read word and the store operands are registered. A store that hit is written into the data array at the end of the write stage, one cycle after its lookup, so no store ever touches the array before its hit is known. A miss blocks the write and raises a stall flag on the response.

Because a store commits one cycle late, a load issued right behind a store to the same word reads the array in the very cycle that the store writes it, and that read value cannot be trusted. The block compares the load's word address with the store held in the write stage. On a match it takes the store's latched data for every enabled byte and the array word only for the bytes the store did not write. A separate fill port installs a full word together with its tag and valid bit. It is the write side of a refill path whose control is outside this block.

The write stage works as a small state machine whose state is the kind of access it holds. `MW_IDLE` means no request. `MW_LOAD` is a load that hit. `MW_STORE` is a store that hit, and it is the only state that writes the array. `MW_MISS` is any access whose tag did not match. Every cycle the next state is picked from the read stage. With no request valid it is `MW_IDLE`. A valid request that misses goes to `MW_MISS`. A store that hits goes to `MW_STORE` and a load that hits goes to `MW_LOAD`. Any state can move to any other in one cycle. Reset enters `MW_IDLE`.

Top module: `dc_pipe`

## Requirements
- R1: After reset every line is invalid, so the first access to any line misses, and the response outputs are idle (all low, data zero) until a request has passed the read stage.
- R2: A request sampled on a rising edge produces its response during the following cycle: `rsp_valid` equals the previous cycle's `req_valid`, and `rsp_store` is high exactly when that request was a valid store.
- R3: The word address is split with the index in its low log2(LINES) bits and the tag in the remaining high bits. A request hits when its line is valid and the stored tag equals its tag. For a valid response exactly one of `rsp_hit` and `rsp_stall` is high, and for no response neither is.
- R4: A load that hits returns on `rsp_data` the current word of its line. `rsp_data` is zero whenever the response is not a load hit.
- R5: A store that misses leaves the data array unchanged; a later load of that line returns the old word.
- R6: A store that hits writes only the bytes whose `req_be` bit is set, bit i selecting data bits 8i+7 down to 8i; the other bytes of the word keep their value.
- R7: A load issued in the cycle right after a hitting store to the same word address returns the store's enabled bytes merged over the array word, never the array word alone.
- R8: A fill installs tag, valid bit and full data word for its index at the next edge. A later request to the same index with a different tag misses. Stores never change tags or valid bits. A fill must not be driven in a cycle where a hitting store occupies the write stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present in the read stage |
| req_store | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte enables |
| fill_valid | input | 1 | Install a word into the cache |
| fill_addr | input | ADDR_W | Word address of the fill |
| fill_data | input | 32 | Word written by the fill |
| rsp_valid | output | 1 | Response present in the write stage |
| rsp_store | output | 1 | Response belongs to a store |
| rsp_hit | output | 1 | Access hit |
| rsp_stall | output | 1 | Access missed; upstream must stall |
| rsp_data | output | 32 | Load result, zero unless a load hit |

## Verification
The checker watches every cycle that a request turns into a response one cycle later with its kind preserved. It also checks that a valid response carries exactly one of hit and stall, that data stays zero outside a load hit, and that a stalled access never writes the array. What is actually stored, the byte-enable merge, the untouched array after a missed store, tag replacement by a fill, and the correctness of the store-to-load bypass are all visible only through later loads. The bench's reference model, its directed sequences and its back-to-back random traffic over a small pool of addresses show these.

// File: rtl/dc_pkg.sv
package dc_pkg;

    localparam int WORD_W = 32;
    localparam int BYTES  = WORD_W / 8;

    typedef enum logic [1:0] {
        MW_IDLE  = 2'd0,
        MW_LOAD  = 2'd1,
        MW_STORE = 2'd2,
        MW_MISS  = 2'd3
    } mw_state_e;

endpackage

// File: rtl/dc_tag_array.sv
module dc_tag_array #(
    parameter int LINES = 16,
    parameter int IDX_W = 4,
    parameter int TAG_W = 26
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    input  logic [TAG_W-1:0] rd_tag,
    output logic             rd_hit,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);

    logic [LINES-1:0] line_ok;
    logic [TAG_W-1:0] tag_mem [LINES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_ok <= '0;
        end else if (wr_en) begin
            line_ok[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_mem[wr_idx] <= wr_tag;
        end
    end

    assign rd_hit = line_ok[rd_idx] && (tag_mem[rd_idx] == rd_tag);

endmodule

// File: rtl/dc_data_array.sv
module dc_data_array
    import dc_pkg::*;
#(
    parameter int LINES = 16,
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BYTES-1:0]  wr_be,
    input  logic [WORD_W-1:0] wr_word
);

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        logic [7:0] lane_mem [LINES];

        always_ff @(posedge clk) begin
            if (wr_en && wr_be[b]) begin
                lane_mem[wr_idx] <= wr_word[8*b +: 8];
            end
        end

        assign rd_word[8*b +: 8] = lane_mem[rd_idx];
    end

endmodule

// File: rtl/dc_bypass.sv
module dc_bypass
    import dc_pkg::*;
(
    input  logic              collide,
    input  logic [WORD_W-1:0] arr_word,
    input  logic [WORD_W-1:0] st_word,
    input  logic [BYTES-1:0]  st_be,
    output logic [WORD_W-1:0] out_word
);

    for (genvar b = 0; b < BYTES; b++) begin : g_byte
        assign out_word[8*b +: 8] = (collide && st_be[b]) ? st_word[8*b +: 8]
                                                           : arr_word[8*b +: 8];
    end

endmodule

// File: rtl/dc_pipe.sv
module dc_pipe
    import dc_pkg::*;
#(
    parameter int ADDR_W = 30,
    parameter int LINES  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_store,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [3:0]        req_be,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [31:0]       fill_data,
    output logic              rsp_valid,
    output logic              rsp_store,
    output logic              rsp_hit,
    output logic              rsp_stall,
    output logic [31:0]       rsp_data
);

    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    // read stage
    logic [IDX_W-1:0]  mr_idx;
    logic [TAG_W-1:0]  mr_tag;
    logic              mr_hit;
    logic [WORD_W-1:0] mr_arr_word;
    logic [WORD_W-1:0] mr_word;
    logic              mr_collide;

    // write stage
    mw_state_e         mw_state, mw_next;
    logic [ADDR_W-1:0] mw_addr;
    logic [WORD_W-1:0] mw_wdata;
    logic [BYTES-1:0]  mw_be;
    logic [WORD_W-1:0] mw_word;
    logic              store_we;

    // array write port
    logic              arr_we;
    logic [IDX_W-1:0]  arr_widx;
    logic [BYTES-1:0]  arr_wbe;
    logic [WORD_W-1:0] arr_wword;

    assign mr_idx = req_addr[IDX_W-1:0];
    assign mr_tag = req_addr[ADDR_W-1:IDX_W];

    dc_tag_array #(
        .LINES (LINES),
        .IDX_W (IDX_W),
        .TAG_W (TAG_W)
    ) u_tags (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (mr_idx),
        .rd_tag (mr_tag),
        .rd_hit (mr_hit),
        .wr_en  (fill_valid),
        .wr_idx (fill_addr[IDX_W-1:0]),
        .wr_tag (fill_addr[ADDR_W-1:IDX_W])
    );

    dc_data_array #(
        .LINES (LINES),
        .IDX_W (IDX_W)
    ) u_data (
        .clk     (clk),
        .rd_idx  (mr_idx),
        .rd_word (mr_arr_word),
        .wr_en   (arr_we),
        .wr_idx  (arr_widx),
        .wr_be   (arr_wbe),
        .wr_word (arr_wword)
    );

    // same-word load right behind a committing store
    assign mr_collide = (mw_state == MW_STORE) && req_valid && !req_store
                        && (req_addr == mw_addr);

    dc_bypass u_byp (
        .collide  (mr_collide),
        .arr_word (mr_arr_word),
        .st_word  (mw_wdata),
        .st_be    (mw_be),
        .out_word (mr_word)
    );

    // next state of the write stage
    always_comb begin
        if (!req_valid) begin
            mw_next = MW_IDLE;
        end else if (!mr_hit) begin
            mw_next = MW_MISS;
        end else if (req_store) begin
            mw_next = MW_STORE;
        end else begin
            mw_next = MW_LOAD;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mw_state <= MW_IDLE;
        end else begin
            mw_state <= mw_next;
        end
    end

    // stage boundary registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mw_addr  <= '0;
            mw_wdata <= '0;
            mw_be    <= '0;
            mw_word  <= '0;
        end else begin
            mw_addr  <= req_addr;
            mw_wdata <= req_wdata;
            mw_be    <= req_be;
            mw_word  <= mr_word;
        end
    end

    // outputs of the write stage
    always_comb begin
        rsp_valid = 1'b0;
        rsp_store = 1'b0;
        rsp_hit   = 1'b0;
        rsp_stall = 1'b0;
        rsp_data  = '0;
        store_we  = 1'b0;
        unique case (mw_state)
            MW_IDLE: begin
            end
            MW_LOAD: begin
                rsp_valid = 1'b1;
                rsp_hit   = 1'b1;
                rsp_data  = mw_word;
            end
            MW_STORE: begin
                rsp_valid = 1'b1;
                rsp_store = 1'b1;
                rsp_hit   = 1'b1;
                store_we  = 1'b1;
            end
            MW_MISS: begin
                rsp_valid = 1'b1;
                rsp_store = req_store_q;
                rsp_stall = 1'b1;
            end
        endcase
    end

    // kind of a missed access, kept for the response
    logic req_store_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_store_q <= 1'b0;
        end else begin
            req_store_q <= req_valid && req_store;
        end
    end

    // array write port: fill has priority
    always_comb begin
        if (fill_valid) begin
            arr_we    = 1'b1;
            arr_widx  = fill_addr[IDX_W-1:0];
            arr_wbe   = '1;
            arr_wword = fill_data;
        end else begin
            arr_we    = store_we;
            arr_widx  = mw_addr[IDX_W-1:0];
            arr_wbe   = mw_be;
            arr_wword = mw_wdata;
        end
    end

endmodule

module dc_pipe_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_store,
    input logic        rsp_valid,
    input logic        rsp_store,
    input logic        rsp_hit,
    input logic        rsp_stall,
    input logic [31:0] rsp_data,
    input logic        store_we
);

    a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r2_idle_follows_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r2_store_kind: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_store) |=> rsp_store);

    a_r3_hit_or_stall: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_hit ^ rsp_stall));

    a_r3_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && !rsp_stall));

    a_r4_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && !rsp_store && rsp_hit) |-> (rsp_data == 32'd0));

    a_r5_no_write_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_stall |-> !store_we);

endmodule

bind dc_pipe dc_pipe_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_store (req_store),
    .rsp_valid (rsp_valid),
    .rsp_store (rsp_store),
    .rsp_hit   (rsp_hit),
    .rsp_stall (rsp_stall),
    .rsp_data  (rsp_data),
    .store_we  (store_we)
);

// File: tb/dc_pipe_tb.sv
module dc_pipe_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 30;
    localparam int LINES  = 16;
    localparam int IW     = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_store = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic [3:0]        req_be = '0;
    logic              fill_valid = 1'b0;
    logic [ADDR_W-1:0] fill_addr = '0;
    logic [31:0]       fill_data = '0;
    logic              rsp_valid, rsp_store, rsp_hit, rsp_stall;
    logic [31:0]       rsp_data;

    always #(CLK_PERIOD/2) clk = ~clk;

    dc_pipe #(.ADDR_W(ADDR_W), .LINES(LINES)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_store(req_store), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_be(req_be),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
        .rsp_valid(rsp_valid), .rsp_store(rsp_store), .rsp_hit(rsp_hit),
        .rsp_stall(rsp_stall), .rsp_data(rsp_data)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model
    bit                  m_ok  [LINES];
    logic [ADDR_W-IW-1:0] m_tag [LINES];
    logic [31:0]         m_word[LINES];

    // expected response of the request in flight
    logic [3:0]  p_stat = 4'b0;
    logic [31:0] p_data = '0;
    string       p_tag  = "R1";

    // previous request, for spotting the bypass case
    bit          last_st_hit = 0;
    logic [ADDR_W-1:0] last_addr = '0;

    function automatic logic [31:0] merge(input logic [31:0] old_w, new_w,
                                          input logic [3:0] be);
        logic [31:0] r = old_w;
        for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = new_w[8*b +: 8];
        return r;
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic cyc(input bit v, input bit st, input logic [ADDR_W-1:0] a,
                       input logic [31:0] wd, input logic [3:0] be,
                       input bit fv, input logic [ADDR_W-1:0] fa,
                       input logic [31:0] fd, input string tag);
        int idx;
        bit hit;
        @(negedge clk);
        chk(p_tag, "status", {28'd0, rsp_valid, rsp_store, rsp_hit, rsp_stall},
            {28'd0, p_stat});
        chk(p_tag, "data", rsp_data, p_data);
        req_valid = v; req_store = st; req_addr = a; req_wdata = wd; req_be = be;
        fill_valid = fv; fill_addr = fa; fill_data = fd;
        idx = int'(a[IW-1:0]);
        hit = v && m_ok[idx] && (m_tag[idx] == a[ADDR_W-1:IW]);
        p_stat = {v, v && st, hit, v && !hit};
        p_data = (hit && !st) ? m_word[idx] : 32'd0;
        p_tag  = (v && !st && last_st_hit && a == last_addr) ? "R7" : tag;
        if (hit && st) m_word[idx] = merge(m_word[idx], wd, be);
        last_st_hit = hit && st;
        last_addr = a;
        if (fv) begin
            m_ok[int'(fa[IW-1:0])]   = 1'b1;
            m_tag[int'(fa[IW-1:0])]  = fa[ADDR_W-1:IW];
            m_word[int'(fa[IW-1:0])] = fd;
        end
    endtask

    task automatic idle(input string tag);
        cyc(0, 0, '0, '0, '0, 0, '0, '0, tag);
    endtask

    task automatic fill(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        idle("R8");
        cyc(0, 0, '0, '0, '0, 1, a, d, "R8");
    endtask

    task automatic ld(input logic [ADDR_W-1:0] a, input string tag);
        cyc(1, 0, a, '0, '0, 0, '0, '0, tag);
    endtask

    task automatic st(input logic [ADDR_W-1:0] a, input logic [31:0] d,
                      input logic [3:0] be, input string tag);
        cyc(1, 1, a, d, be, 0, '0, '0, tag);
    endtask

    function automatic logic [ADDR_W-1:0] mk(input int t, input int i);
        return {ADDR_W'(t), IW'(0)} | ADDR_W'(i);
    endfunction

    initial begin
        repeat (CLK_PERIOD * 200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd2024);
        for (int i = 0; i < LINES; i++) begin
            m_ok[i] = 0; m_tag[i] = '0; m_word[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: idle outputs, then every line misses
        idle("R1");
        for (int i = 0; i < LINES; i++) ld(mk(i % 3, i), "R1");
        st(mk(0, 5), 32'hdead_beef, 4'hf, "R1");

        // R8 R4: fill then load hits with the word
        fill(mk(1, 3), 32'h1122_3344);
        ld(mk(1, 3), "R4");
        ld(mk(2, 3), "R8");

        // R5: store to a missing tag leaves line untouched
        st(mk(2, 3), 32'hffff_ffff, 4'hf, "R5");
        idle("R5");
        ld(mk(1, 3), "R5");

        // R6: partial byte write
        st(mk(1, 3), 32'haabb_ccdd, 4'b0101, "R6");
        idle("R6");
        ld(mk(1, 3), "R6");
        st(mk(1, 3), 32'h99xx_xx00 & 32'h9900_0000, 4'b1000, "R6");
        idle("R6");
        ld(mk(1, 3), "R6");

        // R7: store immediately followed by load to the same word
        st(mk(1, 3), 32'h5566_7788, 4'b0011, "R7");
        ld(mk(1, 3), "R7");
        st(mk(1, 3), 32'h0102_0304, 4'b1111, "R7");
        ld(mk(1, 3), "R7");
        fill(mk(1, 4), 32'h0);
        st(mk(1, 3), 32'hcafe_0000, 4'b1100, "R7");
        ld(mk(1, 4), "R3");
        ld(mk(1, 3), "R4");

        // R8: refill with a new tag evicts the old one
        fill(mk(3, 3), 32'h7777_0000);
        ld(mk(1, 3), "R8");
        ld(mk(3, 3), "R8");

        // random traffic over a small pool
        for (int n = 0; n < 4000; n++) begin
            int r = int'($urandom_range(99));
            logic [ADDR_W-1:0] a = mk(int'($urandom_range(2)), int'($urandom_range(LINES-1)));
            if (r < 10) begin
                fill(a, $urandom());
            end else if (r < 20) begin
                idle("R2");
            end else if (r < 35 && last_st_hit) begin
                ld(last_addr, "R7");
            end else if (r < 60) begin
                st(a, $urandom(), 4'($urandom_range(15)), "R6");
            end else begin
                ld(a, "R4");
            end
        end
        idle("R2");
        idle("R2");

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule